// File: doc/BRIEF.md
# IDE Task-File Configuration Trapdoor

This block sits between a host and the eight-register task-file port of an IDE channel. While locked it is invisible: every read and write goes straight through to the drive side, with the same offset, width and data, and read data comes back unchanged. A hidden knock made of ordinary task-file accesses opens a configuration window. Inside that window, byte writes to selected offsets land in internal timing and control registers and never reach the drive. A closing code written to the same offset shuts the window again.

The registers hold a read-cycle and a write-cycle timing byte for each device on the channel, a shared address-setup count and a commit register. The timing bytes pack an active count and a recovery count. The block only stores them and drives them out on ports; the logic that generates the strobes uses those ports. Until the commit code is written, the outputs carry the slowest-mode defaults for whichever of the two bus clock speeds the strap input reports. A probe register lets software read that strap.

Top module: `ide_cfg_trapdoor`

## Requirements
- R1: While locked, each access is forwarded in the same cycle. A read raises `drv_rd_o`, a write raises `drv_wr_o`, and at most one of them is high. Offset, width and write data are copied, and `acc_rdata_o` equals `drv_rdata_i`.
- R2: The window opens from the cycle after this sequence: two consecutive 16-bit reads (`acc_wide_i`=1) of offset 1, then a byte write (`acc_wide_i`=0) of 0x03 to offset 2. All three accesses are still forwarded to the drive.
- R3: Any other access that arrives before the 0x03 write resets the knock detector, so another two fresh 16-bit reads of offset 1 are needed. This includes a byte read of offset 1, a read of another offset and a third read of offset 1.
- R4: While open, a byte write of 0x83 to offset 2 locks the block from the next cycle. Any other write to offset 2 leaves the window open. No write to offset 2 is forwarded while open.
- R5: While open, accesses to offsets 0, 1, 3, 5 and 6 reach internal registers and raise neither drive strobe. Reads return the register in bits 7:0 with zeros above: offset 0 gives the read timing of the selected bank, 1 the write timing of the selected bank, 3 the commit register and 6 the select register. Offsets 4 and 7, and reads of offset 2, are forwarded.
- R6: Bit 0 of the select register (offset 6) chooses the device bank (0 or 1) that later offset-0 and offset-1 writes update. Bits 5:4 hold the shared address-setup count. Device d appears in bits 8d+7:8d of `rd_timing_o` and `wr_timing_o`.
- R7: Offset 5 reads as bit 0 = `clk_sel_i`, all other bits zero, only while the strap register holds 0xFF. It reads as zero otherwise.
- R8: After reset the block is locked and `override_o` is 0. While `override_o` is 0, every device field shows 0x6B and `addr_setup_o` shows 3 when `clk_sel_i`=0. They show 0x58 and 2 when `clk_sel_i`=1.
- R9: `override_o` is 1 exactly while the commit register holds 0x85. While it is 1, the outputs show the programmed timing bytes and address-setup count. Writing any other value returns them to the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_wide_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_addr_i | input | 3 | Task-file offset |
| acc_wdata_i | input | DW | Host write data |
| acc_rdata_o | output | DW | Read data returned to the host |
| drv_rd_o | output | 1 | Drive-side read strobe |
| drv_wr_o | output | 1 | Drive-side write strobe |
| drv_wide_o | output | 1 | Drive-side access width |
| drv_addr_o | output | 3 | Drive-side offset |
| drv_wdata_o | output | DW | Drive-side write data |
| drv_rdata_i | input | DW | Drive-side read data |
| clk_sel_i | input | 1 | Strap reporting which bus clock speed is in use |
| cfg_mode_o | output | 1 | Configuration window open |
| override_o | output | 1 | Programmed timings in force |
| rd_timing_o | output | 8*NUM_DEV | Effective read timing, one byte per device |
| wr_timing_o | output | 8*NUM_DEV | Effective write timing, one byte per device |
| addr_setup_o | output | 2 | Effective shared address-setup count |

## Verification
Two events can meet in one cycle: a change of the strap input `clk_sel_i` and the commit write that raises `override_o`. The bench flips the strap in the same cycle as the 0x85 write. Before the edge, the outputs must already show the defaults for the new clock. After the edge, they must show the programmed bytes, with no stale default in between. A second overlap is the close code arriving while the commit is already in force. The bench checks that locking changes nothing on the timing outputs and only stops interception.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int TIM_W = 8;

  typedef enum logic [1:0] {
    KN_IDLE,
    KN_ONE,
    KN_TWO,
    KN_OPEN
  } knock_e;

  localparam logic [2:0] OFS_RDT = 3'd0;
  localparam logic [2:0] OFS_WRT = 3'd1;
  localparam logic [2:0] OFS_KEY = 3'd2;
  localparam logic [2:0] OFS_CTL = 3'd3;
  localparam logic [2:0] OFS_STR = 3'd5;
  localparam logic [2:0] OFS_SEL = 3'd6;
  localparam logic [2:0] OFS_KNOCK = 3'd1;

  localparam logic [7:0] KEY_OPEN    = 8'h03;
  localparam logic [7:0] KEY_CLOSE   = 8'h83;
  localparam logic [7:0] CTL_COMMIT  = 8'h85;
  localparam logic [7:0] STRAP_PROBE = 8'hFF;

  localparam logic [TIM_W-1:0] DEF_TIM_C0 = 8'h6B;
  localparam logic [TIM_W-1:0] DEF_TIM_C1 = 8'h58;
  localparam logic [1:0]       DEF_SET_C0 = 2'd3;
  localparam logic [1:0]       DEF_SET_C1 = 2'd2;

  function automatic logic is_reg_ofs(input logic [2:0] a);
    return (a == OFS_RDT) || (a == OFS_WRT) || (a == OFS_CTL) ||
           (a == OFS_STR) || (a == OFS_SEL);
  endfunction
endpackage

// File: rtl/ide_knock_fsm.sv
module ide_knock_fsm
  import ide_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       write_i,
  input  logic       wide_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wbyte_i,
  output logic       open_o
);
  knock_e st_q, st_d;
  logic   is_knock, is_open, is_close;

  assign is_knock = !write_i && wide_i && (addr_i == OFS_KNOCK);
  assign is_open  = write_i && !wide_i && (addr_i == OFS_KEY) && (wbyte_i == KEY_OPEN);
  assign is_close = write_i && !wide_i && (addr_i == OFS_KEY) && (wbyte_i == KEY_CLOSE);

  always_comb begin
    st_d = st_q;
    if (valid_i) begin
      unique case (st_q)
        KN_IDLE: st_d = is_knock ? KN_ONE : KN_IDLE;
        KN_ONE:  st_d = is_knock ? KN_TWO : KN_IDLE;
        KN_TWO:  st_d = is_open  ? KN_OPEN : KN_IDLE;
        KN_OPEN: st_d = is_close ? KN_IDLE : KN_OPEN;
        default: st_d = KN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KN_IDLE;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == KN_OPEN);
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [2:0]               addr_i,
  input  logic [7:0]               wbyte_i,
  input  logic                     clk_sel_i,
  output logic [7:0]               rbyte_o,
  output logic [NUM_DEV*TIM_W-1:0] prog_rd_o,
  output logic [NUM_DEV*TIM_W-1:0] prog_wr_o,
  output logic [1:0]               prog_setup_o,
  output logic                     commit_o
);
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [TIM_W-1:0] rd_q [NUM_DEV];
  logic [TIM_W-1:0] wr_q [NUM_DEV];
  logic [7:0]       ctl_q, sel_q, str_q;
  logic [SEL_W-1:0] bank;

  assign bank = sel_q[SEL_W-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[d] <= '0;
        wr_q[d] <= '0;
      end else if (wr_en_i && (bank == SEL_W'(d))) begin
        if (addr_i == OFS_RDT) rd_q[d] <= wbyte_i[TIM_W-1:0];
        if (addr_i == OFS_WRT) wr_q[d] <= wbyte_i[TIM_W-1:0];
      end
    end
    assign prog_rd_o[d*TIM_W +: TIM_W] = rd_q[d];
    assign prog_wr_o[d*TIM_W +: TIM_W] = wr_q[d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      sel_q <= '0;
      str_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_CTL) ctl_q <= wbyte_i;
      if (addr_i == OFS_SEL) sel_q <= wbyte_i;
      if (addr_i == OFS_STR) str_q <= wbyte_i;
    end
  end

  always_comb begin
    rbyte_o = '0;
    unique case (addr_i)
      OFS_RDT: rbyte_o = 8'(rd_q[bank]);
      OFS_WRT: rbyte_o = 8'(wr_q[bank]);
      OFS_CTL: rbyte_o = ctl_q;
      OFS_SEL: rbyte_o = sel_q;
      OFS_STR: rbyte_o = (str_q == STRAP_PROBE) ? {7'd0, clk_sel_i} : 8'd0;
      default: rbyte_o = '0;
    endcase
  end

  assign prog_setup_o = sel_q[5:4];
  assign commit_o     = (ctl_q == CTL_COMMIT);
endmodule

// File: rtl/ide_timing_out.sv
module ide_timing_out
  import ide_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic                     override_i,
  input  logic                     clk_sel_i,
  input  logic [NUM_DEV*TIM_W-1:0] prog_rd_i,
  input  logic [NUM_DEV*TIM_W-1:0] prog_wr_i,
  input  logic [1:0]               prog_setup_i,
  output logic [NUM_DEV*TIM_W-1:0] rd_timing_o,
  output logic [NUM_DEV*TIM_W-1:0] wr_timing_o,
  output logic [1:0]               addr_setup_o
);
  logic [TIM_W-1:0] def_tim;

  assign def_tim = clk_sel_i ? DEF_TIM_C1 : DEF_TIM_C0;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign rd_timing_o[d*TIM_W +: TIM_W] = override_i ? prog_rd_i[d*TIM_W +: TIM_W] : def_tim;
    assign wr_timing_o[d*TIM_W +: TIM_W] = override_i ? prog_wr_i[d*TIM_W +: TIM_W] : def_tim;
  end

  assign addr_setup_o = override_i ? prog_setup_i : (clk_sel_i ? DEF_SET_C1 : DEF_SET_C0);
endmodule

// File: rtl/ide_cfg_trapdoor.sv
module ide_cfg_trapdoor
  import ide_cfg_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NUM_DEV = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_valid_i,
  input  logic                     acc_write_i,
  input  logic                     acc_wide_i,
  input  logic [2:0]               acc_addr_i,
  input  logic [DW-1:0]            acc_wdata_i,
  output logic [DW-1:0]            acc_rdata_o,
  output logic                     drv_rd_o,
  output logic                     drv_wr_o,
  output logic                     drv_wide_o,
  output logic [2:0]               drv_addr_o,
  output logic [DW-1:0]            drv_wdata_o,
  input  logic [DW-1:0]            drv_rdata_i,
  input  logic                     clk_sel_i,
  output logic                     cfg_mode_o,
  output logic                     override_o,
  output logic [NUM_DEV*TIM_W-1:0] rd_timing_o,
  output logic [NUM_DEV*TIM_W-1:0] wr_timing_o,
  output logic [1:0]               addr_setup_o
);
  logic                     open_q, cfg_hit, cfg_wr, commit;
  logic [7:0]               reg_rbyte;
  logic [NUM_DEV*TIM_W-1:0] prog_rd, prog_wr;
  logic [1:0]               prog_setup;

  ide_knock_fsm i_knock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .wide_i  (acc_wide_i),
    .addr_i  (acc_addr_i),
    .wbyte_i (acc_wdata_i[7:0]),
    .open_o  (open_q)
  );

  // offset 2 is intercepted only for writes (close/ignore), reads still reach the drive
  assign cfg_hit = open_q && (is_reg_ofs(acc_addr_i) || (acc_write_i && acc_addr_i == OFS_KEY));
  assign cfg_wr  = acc_valid_i && acc_write_i && open_q && is_reg_ofs(acc_addr_i);

  ide_cfg_regs #(.NUM_DEV(NUM_DEV)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (cfg_wr),
    .addr_i       (acc_addr_i),
    .wbyte_i      (acc_wdata_i[7:0]),
    .clk_sel_i    (clk_sel_i),
    .rbyte_o      (reg_rbyte),
    .prog_rd_o    (prog_rd),
    .prog_wr_o    (prog_wr),
    .prog_setup_o (prog_setup),
    .commit_o     (commit)
  );

  ide_timing_out #(.NUM_DEV(NUM_DEV)) i_tout (
    .override_i   (commit),
    .clk_sel_i    (clk_sel_i),
    .prog_rd_i    (prog_rd),
    .prog_wr_i    (prog_wr),
    .prog_setup_i (prog_setup),
    .rd_timing_o  (rd_timing_o),
    .wr_timing_o  (wr_timing_o),
    .addr_setup_o (addr_setup_o)
  );

  assign drv_rd_o    = acc_valid_i && !acc_write_i && !cfg_hit;
  assign drv_wr_o    = acc_valid_i &&  acc_write_i && !cfg_hit;
  assign drv_wide_o  = acc_wide_i;
  assign drv_addr_o  = acc_addr_i;
  assign drv_wdata_o = acc_wdata_i;
  assign acc_rdata_o = cfg_hit ? {{(DW-8){1'b0}}, reg_rbyte} : drv_rdata_i;
  assign cfg_mode_o  = open_q;
  assign override_o  = commit;
endmodule

// File: rtl/ide_cfg_trapdoor_chk.sv
module ide_cfg_trapdoor_chk #(
  parameter int DW      = 16,
  parameter int NUM_DEV = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 acc_valid_i,
  input logic                 acc_write_i,
  input logic                 acc_wide_i,
  input logic [2:0]           acc_addr_i,
  input logic [DW-1:0]        acc_wdata_i,
  input logic                 drv_rd_o,
  input logic                 drv_wr_o,
  input logic                 clk_sel_i,
  input logic                 cfg_mode_o,
  input logic                 override_o,
  input logic [NUM_DEV*8-1:0] rd_timing_o
);
  logic key_open_wr, key_close_wr, reg_ofs;

  assign key_open_wr  = acc_valid_i && acc_write_i && !acc_wide_i &&
                        acc_addr_i == 3'd2 && acc_wdata_i[7:0] == 8'h03;
  assign key_close_wr = acc_valid_i && acc_write_i && !acc_wide_i &&
                        acc_addr_i == 3'd2 && acc_wdata_i[7:0] == 8'h83;
  assign reg_ofs      = acc_addr_i inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6};

  a_r1_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drv_rd_o, drv_wr_o}));

  a_r1_locked_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && acc_valid_i) |-> (drv_wr_o == acc_write_i && drv_rd_o == !acc_write_i));

  a_r2_open_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(key_open_wr));

  a_r4_close_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && key_close_wr) |=> !cfg_mode_o);

  a_r5_no_cfg_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && acc_valid_i && acc_write_i && reg_ofs) |-> !drv_wr_o);

  a_r8_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !override_o |-> rd_timing_o == {NUM_DEV{clk_sel_i ? 8'h58 : 8'h6B}});
endmodule

bind ide_cfg_trapdoor ide_cfg_trapdoor_chk #(.DW(DW), .NUM_DEV(NUM_DEV)) i_chk (.*);

// File: tb/test_ide_cfg_trapdoor.sv
module test_ide_cfg_trapdoor;
  localparam int DW = 16;
  localparam int ND = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0, wide = 1'b0, clk_sel = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, drv_wdata, drv_rdata;
  logic drv_rd, drv_wr, drv_wide, cfg_mode, override;
  logic [2:0] drv_addr;
  logic [ND*8-1:0] rd_tim, wr_tim;
  logic [1:0] setup;

  int n_run = 0, n_fail = 0;
  logic s_rd, s_wr;
  logic [DW-1:0] s_rdata, s_wdata;
  logic [2:0] s_addr;

  always #10 clk = ~clk;

  assign drv_rdata = 16'hA500 | {13'd0, drv_addr};

  ide_cfg_trapdoor #(.DW(DW), .NUM_DEV(ND)) i_ide_cfg_trapdoor (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(valid), .acc_write_i(write), .acc_wide_i(wide),
    .acc_addr_i(addr), .acc_wdata_i(wdata), .acc_rdata_o(rdata),
    .drv_rd_o(drv_rd), .drv_wr_o(drv_wr), .drv_wide_o(drv_wide),
    .drv_addr_o(drv_addr), .drv_wdata_o(drv_wdata), .drv_rdata_i(drv_rdata),
    .clk_sel_i(clk_sel), .cfg_mode_o(cfg_mode), .override_o(override),
    .rd_timing_o(rd_tim), .wr_timing_o(wr_tim), .addr_setup_o(setup)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic wd, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    valid = 1'b1; write = w; wide = wd; addr = a; wdata = d;
    #2;
    s_rd = drv_rd; s_wr = drv_wr; s_rdata = rdata; s_wdata = drv_wdata; s_addr = drv_addr;
    @(posedge clk);
    #1;
    valid = 1'b0; write = 1'b0; wide = 1'b0;
  endtask

  task automatic unlock();
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b1, 1'b0, 3'd2, 16'h0003);
  endtask

  task automatic t_reset();
    chk("R8 locked after reset", cfg_mode, 0);
    chk("R8 override off", override, 0);
    chk("R8 rd default c0", rd_tim, 16'h6B6B);
    chk("R8 wr default c0", wr_tim, 16'h6B6B);
    chk("R8 setup default c0", setup, 2'd3);
  endtask

  task automatic t_passthru();
    acc(1'b0, 1'b1, 3'd4, 16'h0);
    chk("R1 read strobe", {s_rd, s_wr}, 2'b10);
    chk("R1 read data", s_rdata, 16'hA504);
    acc(1'b1, 1'b0, 3'd3, 16'h1255);
    chk("R1 write strobe", {s_rd, s_wr}, 2'b01);
    chk("R1 write data/addr", {s_addr, s_wdata}, {3'd3, 16'h1255});
    chk("R1 still locked", cfg_mode, 0);
  endtask

  task automatic t_unlock();
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    chk("R2 knock1 forwarded", s_rd, 1);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    chk("R2 knock2 forwarded", s_rd, 1);
    chk("R2 not open after reads", cfg_mode, 0);
    acc(1'b1, 1'b0, 3'd2, 16'h0003);
    chk("R2 key write forwarded", s_wr, 1);
    chk("R2 window open", cfg_mode, 1);
  endtask

  task automatic t_relock();
    acc(1'b1, 1'b0, 3'd2, 16'h0010);
    chk("R4 other key not forwarded", s_wr, 0);
    chk("R4 other key keeps open", cfg_mode, 1);
    acc(1'b0, 1'b0, 3'd2, 16'h0);
    chk("R5 read of offset 2 forwarded", {s_rd, s_rdata}, {1'b1, 16'hA502});
    acc(1'b1, 1'b0, 3'd2, 16'h0083);
    chk("R4 close not forwarded", s_wr, 0);
    chk("R4 locked after close", cfg_mode, 0);
  endtask

  task automatic t_broken();
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b0, 1'b1, 3'd3, 16'h0);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b1, 1'b0, 3'd2, 16'h0003);
    chk("R3 other offset breaks knock", cfg_mode, 0);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b0, 1'b0, 3'd1, 16'h0);
    acc(1'b1, 1'b0, 3'd2, 16'h0003);
    chk("R3 byte read breaks knock", cfg_mode, 0);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b0, 1'b1, 3'd1, 16'h0);
    acc(1'b1, 1'b0, 3'd2, 16'h0003);
    chk("R3 third knock read breaks", cfg_mode, 0);
  endtask

  task automatic t_regs();
    unlock();
    acc(1'b1, 1'b0, 3'd6, 16'h0000);
    chk("R5 cfg write not forwarded", s_wr, 0);
    acc(1'b1, 1'b0, 3'd0, 16'h0032);
    acc(1'b1, 1'b0, 3'd1, 16'h0031);
    acc(1'b1, 1'b0, 3'd6, 16'h0021);
    acc(1'b1, 1'b0, 3'd0, 16'h0022);
    acc(1'b1, 1'b0, 3'd1, 16'h0021);
    acc(1'b0, 1'b1, 3'd0, 16'h0);
    chk("R5 read timing bank1", {s_rd, s_rdata}, {1'b0, 16'h0022});
    acc(1'b0, 1'b1, 3'd6, 16'h0);
    chk("R5 select readback", s_rdata, 16'h0021);
    acc(1'b0, 1'b1, 3'd4, 16'h0);
    chk("R5 offset 4 forwarded", {s_rd, s_rdata}, {1'b1, 16'hA504});
    acc(1'b1, 1'b0, 3'd7, 16'h0044);
    chk("R5 offset 7 write forwarded", s_wr, 1);
    chk("R9 defaults before commit", rd_tim, 16'h6B6B);
    acc(1'b1, 1'b0, 3'd3, 16'h0085);
    chk("R9 override on", override, 1);
    chk("R6 rd banks", rd_tim, 16'h2232);
    chk("R6 wr banks", wr_tim, 16'h2131);
    chk("R6 setup field", setup, 2'd2);
    acc(1'b0, 1'b1, 3'd3, 16'h0);
    chk("R5 commit readback", s_rdata, 16'h0085);
    acc(1'b1, 1'b0, 3'd6, 16'h0010);
    acc(1'b0, 1'b1, 3'd0, 16'h0);
    chk("R6 bank0 selected", s_rdata, 16'h0032);
    chk("R6 setup 1", setup, 2'd1);
    acc(1'b1, 1'b0, 3'd3, 16'h0084);
    chk("R9 other value drops override", {override, rd_tim}, {1'b0, 16'h6B6B});
  endtask

  task automatic t_strap();
    acc(1'b0, 1'b1, 3'd5, 16'h0);
    chk("R7 strap reads zero unprobed", {s_rd, s_rdata}, {1'b0, 16'h0000});
    acc(1'b1, 1'b0, 3'd5, 16'h00FF);
    clk_sel = 1'b1;
    acc(1'b0, 1'b1, 3'd5, 16'h0);
    chk("R7 strap probe c1", s_rdata, 16'h0001);
    chk("R8 defaults c1", {rd_tim, wr_tim, setup}, {16'h5858, 16'h5858, 2'd2});
    clk_sel = 1'b0;
    acc(1'b0, 1'b1, 3'd5, 16'h0);
    chk("R7 strap probe c0", s_rdata, 16'h0000);
  endtask

  task automatic t_overlap();
    @(negedge clk);
    valid = 1'b1; write = 1'b1; wide = 1'b0; addr = 3'd3; wdata = 16'h0085; clk_sel = 1'b1;
    #2;
    chk("R8 new-clock defaults same cycle", {override, rd_tim}, {1'b0, 16'h5858});
    @(posedge clk);
    #1;
    valid = 1'b0; write = 1'b0;
    chk("R9 programmed after commit", {override, rd_tim, setup}, {1'b1, 16'h2232, 2'd1});
    acc(1'b1, 1'b0, 3'd2, 16'h0083);
    chk("R4 close keeps timings", {cfg_mode, override, wr_tim}, {1'b0, 1'b1, 16'h2131});
    acc(1'b1, 1'b0, 3'd0, 16'h0099);
    chk("R1 locked write forwarded", s_wr, 1);
    chk("R1 locked write leaves timing", rd_tim, 16'h2232);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_unlock();
    t_relock();
    t_broken();
    t_regs();
    t_strap();
    t_overlap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule